// File: doc/BRIEF.md
# Accumulator ALU with bitwise logic

This block is the arithmetic and logic datapath of a small 8-bit teaching computer. It holds two operand registers, an accumulator A and a second operand B. It can add, subtract, AND, OR or invert, and it always writes the result back into A. Both registers load from the shared system bus. An output enable places A onto the block's bus output.

Five separate control lines select the operations, one line per function. A microcode sequencer outside the block drives these lines. The block does not decode an opcode. It expects at most one operation line per cycle. If no line is high, A is left alone. If two or more lines are high, the block keeps A and raises an error flag. The adder also keeps a carry flag, which the logic operations leave untouched.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high reset clears A, B, the carry flag and the error flag to zero.
- R2: A loads bus_in on a rising edge while a_load is high, and B loads bus_in while b_load is high. When a_load is high, the operation lines neither write A nor change carry.
- R3: With only add_en high, A becomes (A + B) mod 256 and carry takes the ninth sum bit.
- R4: With only sub_en high, A becomes (A - B) mod 256. Carry is set to 1 when A >= B (no borrow) and to 0 otherwise.
- R5: With only and_en high, A becomes A & B. With only or_en high, A becomes A | B. Carry is unchanged in both cases.
- R6: With only not_en high, A becomes ~A whatever B holds, and carry is unchanged.
- R7: With no operation line high and a_load low, A and carry keep their values.
- R8: In a cycle with two or more operation lines high, A and carry keep their values. op_err is high in the following cycle and low after any cycle with at most one operation line high.
- R9: bus_out equals A while a_drive is high and is zero while a_drive is low.
- R10: B changes only through b_load and reset, never through an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Shared bus value for register loads |
| a_load | input | 1 | Load A from bus_in |
| b_load | input | 1 | Load B from bus_in |
| add_en | input | 1 | Select A + B |
| sub_en | input | 1 | Select A - B |
| and_en | input | 1 | Select A & B |
| or_en | input | 1 | Select A \| B |
| not_en | input | 1 | Select ~A |
| a_drive | input | 1 | Drive A onto bus_out |
| bus_out | output | 8 | A when driven, else zero |
| carry | output | 1 | Carry / no-borrow flag of the last add or subtract |
| op_err | output | 1 | More than one operation line was high in the previous cycle |

## Verification
The assertions check on every cycle how each single operation relates the previous A and B to the new A. They also check that carry stays put through logic operations, that A and carry hold when several lines are high, that the error flag follows a conflict, that load has priority over the operations, and that B is stable. The bench's arithmetic sweep over a wide grid of operand pairs is the only place where the exact carry and borrow values of every pair are compared. The same holds for bus gating with a_drive low, for reset in the middle of a run, and for the way the error flag falls back after one clean cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    // Number of operation lines; the index of each line in the operation vector
    localparam int N_OPS = 5;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_NOT = 3'd4
    } op_idx_e;

    typedef logic [N_OPS-1:0] op_vec_t;

    // Decision of the selector for one cycle
    typedef struct packed {
        logic wr_en;   // exactly one line active
        logic multi;   // conflicting lines
        logic c_en;    // carry must be written
        logic c_val;   // new carry value
    } sel_ctl_t;

    // Number of active operation lines
    function automatic int unsigned op_count(op_vec_t v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < N_OPS; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction

    // Operations that produce a carry
    function automatic logic op_is_arith(op_vec_t v);
        return v[OP_ADD] | v[OP_SUB];
    endfunction

endpackage

// File: rtl/acc_reg.sv
module acc_reg #(
    parameter int          W         = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/acc_func_units.sv
module acc_func_units
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    [W-1:0] a,
    input  logic                    [W-1:0] b,
    output logic [N_OPS-1:0][W-1:0]         res,
    output logic                            c_add,
    output logic                            c_sub
);

    localparam int EW = W + 1;

    logic [EW-1:0] sum_ext;
    logic [EW-1:0] dif_ext;

    // Subtract as A + ~B + 1 so the top bit is the no-borrow indication
    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        dif_ext = {1'b0, a} + {1'b0, ~b} + EW'(1);
    end

    assign c_add = sum_ext[W];
    assign c_sub = dif_ext[W];

    assign res[OP_ADD] = sum_ext[W-1:0];
    assign res[OP_SUB] = dif_ext[W-1:0];
    assign res[OP_AND] = a & b;
    assign res[OP_OR]  = a | b;
    assign res[OP_NOT] = ~a;

endmodule

// File: rtl/acc_op_select.sv
module acc_op_select
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_vec_t                         ops,
    input  logic [N_OPS-1:0][W-1:0]         res,
    input  logic                            c_add,
    input  logic                            c_sub,
    output sel_ctl_t                        ctl,
    output logic                    [W-1:0] wr_data
);

    logic [N_OPS-1:0][W-1:0] gated;

    // AND-OR multiplexer, one gate per operation line
    for (genvar g = 0; g < N_OPS; g++) begin : g_gate
        assign gated[g] = ops[g] ? res[g] : '0;
    end

    always_comb begin
        wr_data = '0;
        for (int i = 0; i < N_OPS; i++) begin
            wr_data = wr_data | gated[i];
        end
    end

    always_comb begin
        int unsigned n;
        n         = op_count(ops);
        ctl.wr_en = (n == 1);
        ctl.multi = (n > 1);
        ctl.c_en  = (n == 1) && op_is_arith(ops);
        ctl.c_val = ops[OP_ADD] ? c_add : c_sub;
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    input  logic         a_load,
    input  logic         b_load,
    input  logic         add_en,
    input  logic         sub_en,
    input  logic         and_en,
    input  logic         or_en,
    input  logic         not_en,
    input  logic         a_drive,
    output logic [W-1:0] bus_out,
    output logic         carry,
    output logic         op_err
);

    op_vec_t                 ops;
    logic [N_OPS-1:0][W-1:0] res;
    logic                    c_add;
    logic                    c_sub;
    sel_ctl_t                ctl;
    logic [W-1:0]            wr_data;
    logic [W-1:0]            a_q;
    logic [W-1:0]            b_q;
    logic [W-1:0]            a_d;
    logic                    a_ld;
    logic                    c_ld;

    always_comb begin
        ops          = '0;
        ops[OP_ADD]  = add_en;
        ops[OP_SUB]  = sub_en;
        ops[OP_AND]  = and_en;
        ops[OP_OR]   = or_en;
        ops[OP_NOT]  = not_en;
    end

    acc_func_units #(.W(W)) units_i (
        .a     (a_q),
        .b     (b_q),
        .res   (res),
        .c_add (c_add),
        .c_sub (c_sub)
    );

    acc_op_select #(.W(W)) sel_i (
        .ops     (ops),
        .res     (res),
        .c_add   (c_add),
        .c_sub   (c_sub),
        .ctl     (ctl),
        .wr_data (wr_data)
    );

    // Bus load wins over the write-back of an operation
    assign a_ld = a_load | ctl.wr_en;
    assign a_d  = a_load ? bus_in : wr_data;
    assign c_ld = ctl.c_en & ~a_load;

    acc_reg #(.W(W)) a_reg_i (
        .clk (clk), .rst (rst), .ld (a_ld), .d (a_d), .q (a_q)
    );

    acc_reg #(.W(W)) b_reg_i (
        .clk (clk), .rst (rst), .ld (b_load), .d (bus_in), .q (b_q)
    );

    acc_reg #(.W(1)) c_reg_i (
        .clk (clk), .rst (rst), .ld (c_ld), .d (ctl.c_val), .q (carry)
    );

    acc_reg #(.W(1)) e_reg_i (
        .clk (clk), .rst (rst), .ld (1'b1), .d (ctl.multi), .q (op_err)
    );

    assign bus_out = a_drive ? a_q : '0;

    // ---------------- assertions ----------------
    logic single;
    assign single = ($countones(ops) == 1);

    a_r2_load_prio: assert property (@(posedge clk) disable iff (rst)
        a_load |=> (a_q == $past(bus_in)) && $stable(carry));

    a_r3_add: assert property (@(posedge clk) disable iff (rst)
        (single && add_en && !a_load) |=> a_q == W'($past(a_q) + $past(b_q)));

    a_r4_sub: assert property (@(posedge clk) disable iff (rst)
        (single && sub_en && !a_load) |=> a_q == W'($past(a_q) - $past(b_q)));

    a_r5_logic_carry: assert property (@(posedge clk) disable iff (rst)
        (single && (and_en || or_en || not_en) && !a_load) |=> $stable(carry));

    a_r6_not: assert property (@(posedge clk) disable iff (rst)
        (single && not_en && !a_load) |=> a_q == ~$past(a_q));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ($countones(ops) == 0 && !a_load) |=> $stable(a_q) && $stable(carry));

    a_r8_conflict_hold: assert property (@(posedge clk) disable iff (rst)
        ($countones(ops) > 1 && !a_load) |=> $stable(a_q) && $stable(carry) && op_err);

    a_r10_b_stable: assert property (@(posedge clk) disable iff (rst)
        !b_load |=> $stable(b_q));

endmodule

// File: tb/acc_alu_core_tb_top.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_in = '0;
    logic       a_load = 0, b_load = 0;
    logic       add_en = 0, sub_en = 0, and_en = 0, or_en = 0, not_en = 0;
    logic       a_drive = 1'b1;
    logic [7:0] bus_out;
    logic       carry, op_err;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] ma = '0, mb = '0;
    logic       mc = 1'b0, me = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu_core #(.W(8)) dut_i (
        .clk, .rst, .bus_in, .a_load, .b_load,
        .add_en, .sub_en, .and_en, .or_en, .not_en,
        .a_drive, .bus_out, .carry, .op_err
    );

    task automatic compare(input string tag, input logic drv);
        logic [7:0] eb;
        eb = drv ? ma : 8'h00;
        checks++;
        if (bus_out !== eb || carry !== mc || op_err !== me) begin
            errors++;
            $display("FAIL %s: bus_out=%02h carry=%b op_err=%b expected %02h %b %b",
                     tag, bus_out, carry, op_err, eb, mc, me);
        end
    endtask

    // ops bits: 0 add, 1 sub, 2 and, 3 or, 4 not
    task automatic step(input logic [4:0] ops, input logic la, input logic lb,
                        input logic [7:0] din, input logic drv, input string tag);
        logic [8:0] t;
        logic [7:0] na;
        logic       nc;
        int         n;
        add_en = ops[0]; sub_en = ops[1]; and_en = ops[2];
        or_en  = ops[3]; not_en = ops[4];
        a_load = la; b_load = lb; bus_in = din; a_drive = drv;
        n  = $countones(ops);
        na = ma; nc = mc;
        if (la) begin
            na = din;
        end else if (n == 1) begin
            case (1'b1)
                ops[0]: begin t = {1'b0, ma} + {1'b0, mb}; na = t[7:0]; nc = t[8]; end
                ops[1]: begin na = ma - mb; nc = (ma >= mb); end
                ops[2]: na = ma & mb;
                ops[3]: na = ma | mb;
                default: na = ~ma;
            endcase
        end
        ma = na; mc = nc; me = (n > 1);
        if (lb) mb = din;
        @(posedge clk);
        @(negedge clk);
        compare(tag, drv);
    endtask

    task automatic idle_inputs();
        {add_en, sub_en, and_en, or_en, not_en, a_load, b_load} = '0;
    endtask

    initial begin : watchdog
        #(200000 * 5.0);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        string tg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset; an add of A=0 with B then reveals B
        compare("R1", 1'b1);
        step(5'b00001, 0, 0, 8'h00, 1'b1, "R1");

        // Sweep of operand pairs across every operation (R3 R4 R5 R6)
        for (int a = 0; a < 256; a += 5) begin
            for (int b = 0; b < 256; b += 7) begin
                for (int k = 0; k < 5; k++) begin
                    step(5'b0, 1, 0, 8'(a), 1'b1, "R2");
                    step(5'b0, 0, 1, 8'(b), 1'b1, "R2");
                    case (k)
                        0: tg = "R3";
                        1: tg = "R4";
                        2, 3: tg = "R5";
                        default: tg = "R6";
                    endcase
                    step(5'(1 << k), 0, 0, 8'h00, 1'b1, tg);
                end
            end
        end

        // Edge operands
        step(5'b0, 1, 0, 8'hFF, 1'b1, "R2");
        step(5'b0, 0, 1, 8'h01, 1'b1, "R2");
        step(5'b00001, 0, 0, 8'h00, 1'b1, "R3");
        step(5'b00010, 0, 0, 8'h00, 1'b1, "R4");
        step(5'b10000, 0, 0, 8'h00, 1'b1, "R6");

        // R7: idle cycles keep A and carry
        step(5'b0, 1, 0, 8'hC8, 1'b1, "R2");
        step(5'b0, 0, 1, 8'h64, 1'b1, "R2");
        step(5'b00001, 0, 0, 8'h00, 1'b1, "R3");
        step(5'b0, 0, 0, 8'h5A, 1'b1, "R7");
        step(5'b0, 0, 0, 8'hA5, 1'b1, "R7");

        // R8: conflicting lines hold state and raise op_err for one cycle
        step(5'b00011, 0, 0, 8'h00, 1'b1, "R8");
        step(5'b10100, 0, 0, 8'h00, 1'b1, "R8");
        step(5'b11111, 0, 0, 8'h00, 1'b1, "R8");
        step(5'b01000, 0, 0, 8'h00, 1'b1, "R8");
        step(5'b0, 0, 0, 8'h00, 1'b1, "R8");

        // R2: load takes priority over an operation
        step(5'b00010, 1, 0, 8'h3C, 1'b1, "R2");
        step(5'b00001, 1, 0, 8'hF0, 1'b1, "R2");

        // R9: bus gated to zero while a_drive is low
        step(5'b0, 0, 0, 8'h00, 1'b0, "R9");
        step(5'b10000, 0, 0, 8'h00, 1'b0, "R9");
        step(5'b0, 0, 0, 8'h00, 1'b1, "R9");

        // R10: B unchanged through many operations, read out via OR with A=0
        step(5'b0, 0, 1, 8'h9D, 1'b1, "R2");
        for (int i = 0; i < 20; i++) begin
            step(5'(1 << (i % 5)), 0, 0, 8'h00, 1'b1, "R10");
        end
        step(5'b0, 1, 0, 8'h00, 1'b1, "R2");
        step(5'b01000, 0, 0, 8'h00, 1'b1, "R10");

        // R1: reset during operation
        step(5'b0, 1, 0, 8'hFF, 1'b1, "R2");
        step(5'b00001, 0, 0, 8'h00, 1'b1, "R3");
        step(5'b11000, 0, 0, 8'h00, 1'b1, "R8");
        idle_inputs();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ma = '0; mb = '0; mc = 1'b0; me = 1'b0;
        compare("R1", 1'b1);
        step(5'b01000, 0, 0, 8'h00, 1'b1, "R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule